// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Target

This block is the target end of a 16-bit bus whose lines carry first an address and then a run of data halfwords. The host builds a 32-bit byte address in two steps, each marked by its own active-low latch strobe. It then issues a burst of halfword reads or writes, each marked by an active-low read or write strobe. The target holds the current address in a counter. It completes each access on the rising edge of the strobe and then steps the counter to the next halfword. Behind the counter sits a small synchronous halfword array that stands in for a ROM or SRAM device.

The target answers only when the upper address half matches its configured region. The bus pins are split for a pad cell: `ad_i` is the value seen on the pads, and `ad_o`/`ad_oe` drive them. The target enables its drivers only while it answers an armed read. The bus has no back-pressure. The host paces every phase with its strobes, and the target never stalls it.

All four strobes pass through a flip-flop synchronizer of `SYNC_STAGES` stages. Their edges are detected in the target clock domain, so the clock must run several times faster than the strobe rate. The host must hold `ad_i` steady through each strobe's low phase and for at least `SYNC_STAGES`+2 clocks after a write strobe rises.

Top module: `mbt_target`

## Requirements
- R1: After reset the address counter is zero, the target is disarmed and `ad_oe` is 0.
- R2: A falling edge of `ale_hi_n` loads `ad_i` into address bits [31:16]. The target reads and writes only while those bits equal `REGION_HI` (default 16'h1000). Outside the region a read leaves `ad_oe` at 0 and a write leaves the array unchanged.
- R3: A falling edge of `ale_lo_n` loads `ad_i` into address bits [15:0] and arms the target. A rising edge of `ale_lo_n` changes nothing.
- R4: A rising edge of `ale_hi_n` disarms the target. While disarmed, read and write strobes do not drive the bus, do not write the array and do not move the address. The next falling edge of `ale_lo_n` re-arms the target.
- R5: While armed, each rising edge of `rd_n` or `wr_n` advances the 32-bit address by 2, whatever the region. Any other change of the address comes from a latch strobe falling edge.
- R6: While armed and in region, a rising edge of `wr_n` stores `ad_i` into the array halfword selected by the current address.
- R7: While armed and in region, with `rd_n` low and the other three strobes high, `ad_oe` is 1 and `ad_o` shows the array halfword at the current address. `ad_oe` is 0 while `wr_n` is low and while either latch strobe is low.
- R8: `ad_oe` returns to 0 no later than `SYNC_STAGES`+2 clock edges after `rd_n` rises.
- R9: The array halfword index is address bits [`MEM_AW`:1]. A burst that runs past the top entry wraps to entry 0 as long as the region still matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale_hi_n | input | 1 | Active-low latch strobe for the upper address half |
| ale_lo_n | input | 1 | Active-low latch strobe for the lower address half |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| ad_i | input | 16 | Value seen on the shared address/data pads |
| ad_o | output | 16 | Read data to the pads |
| ad_oe | output | 1 | Pad driver enable |

## Verification
The bound checker watches the address counter, the armed flag and the pad enable on every cycle. It checks that the counter only moves by one halfword or by a latch load. It checks that the latch strobe edges arm and disarm the target in the next cycle. It also checks that the drivers stay off once a write strobe, a latch strobe or a released read strobe has been settled for the synchronizer depth. Whether read data matches what was written, and whether out-of-region or disarmed writes really leave the array untouched, can only be shown by the bench's bursts against its own model. The same holds for index wrap at the top of the array.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
  localparam int NSTB   = 4;
  localparam int STB_AH = 0;
  localparam int STB_AL = 1;
  localparam int STB_RD = 2;
  localparam int STB_WR = 3;
  localparam int DW     = 16;
  localparam int AW     = 32;

  typedef struct packed {
    logic lvl;
    logic fall;
    logic rise;
  } strobe_t;
endpackage

// File: rtl/mbt_strobe_sync.sv
module mbt_strobe_sync
  import mbt_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSTB-1:0]        strobe_n,
  output strobe_t [NSTB-1:0]     stb
);
  for (genvar g = 0; g < NSTB; g++) begin : g_stb
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '1;
        prev  <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], strobe_n[g]};
        prev  <= chain[STAGES-1];
      end
    end
    assign stb[g].lvl  = chain[STAGES-1];
    assign stb[g].fall = prev & ~chain[STAGES-1];
    assign stb[g].rise = ~prev & chain[STAGES-1];
  end
endmodule

// File: rtl/mbt_addr_ctrl.sv
module mbt_addr_ctrl
  import mbt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t [NSTB-1:0] stb,
  input  logic [DW-1:0]      ad_i,
  output logic [AW-1:0]      addr,
  output logic               armed
);
  localparam int HALF = AW / 2;
  logic step;
  assign step = stb[STB_RD].rise | stb[STB_WR].rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= '0;
      armed <= 1'b0;
    end else begin
      if (stb[STB_AH].fall) begin
        addr[AW-1:HALF] <= ad_i;
      end else if (stb[STB_AL].fall) begin
        addr[HALF-1:0] <= ad_i;
        armed          <= 1'b1;
      end else if (stb[STB_AH].rise) begin
        armed <= 1'b0;
      end else if (armed && step) begin
        addr <= addr + AW'(2);
      end
    end
  end
endmodule

// File: rtl/mbt_mem.sv
module mbt_mem #(
  parameter int IW = 8,
  parameter int W  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << IW;
  logic [W-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[idx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= arr[idx];
  end
endmodule

// File: rtl/mbt_target.sv
module mbt_target
  import mbt_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          MEM_AW      = 8,
  parameter logic [15:0] REGION_HI   = 16'h1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ale_hi_n,
  input  logic        ale_lo_n,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic [15:0] ad_i,
  output logic [15:0] ad_o,
  output logic        ad_oe
);
  strobe_t [NSTB-1:0] stb;
  logic [NSTB-1:0]    strobe_n;
  logic [AW-1:0]      addr_q;
  logic               armed_q;
  logic               hit;
  logic [MEM_AW-1:0]  idx;
  logic               we;

  assign strobe_n[STB_AH] = ale_hi_n;
  assign strobe_n[STB_AL] = ale_lo_n;
  assign strobe_n[STB_RD] = rd_n;
  assign strobe_n[STB_WR] = wr_n;

  mbt_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .stb(stb)
  );

  mbt_addr_ctrl u_addr (
    .clk(clk), .rst_n(rst_n), .stb(stb), .ad_i(ad_i),
    .addr(addr_q), .armed(armed_q)
  );

  assign hit = (addr_q[AW-1:AW/2] == REGION_HI);
  assign idx = addr_q[MEM_AW:1];
  assign we  = armed_q & hit & stb[STB_WR].rise;

  mbt_mem #(.IW(MEM_AW), .W(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(we), .idx(idx), .wdata(ad_i), .rdata(ad_o)
  );

  assign ad_oe = armed_q & hit & ~stb[STB_RD].lvl & stb[STB_WR].lvl
               & stb[STB_AH].lvl & stb[STB_AL].lvl;
endmodule

// File: rtl/mbt_target_chk.sv
module mbt_target_chk
  import mbt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ale_hi_n,
  input logic               ale_lo_n,
  input logic               rd_n,
  input logic               wr_n,
  input logic               ad_oe,
  input logic [AW-1:0]      addr_q,
  input logic               armed_q,
  input strobe_t [NSTB-1:0] stb
);
  localparam int LIM = SYNC_STAGES + 1;
  localparam int CW  = $clog2(LIM + 2);
  logic [CW-1:0] rd_hi_cnt, wr_lo_cnt, ale_lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hi_cnt  <= '0;
      wr_lo_cnt  <= '0;
      ale_lo_cnt <= '0;
    end else begin
      rd_hi_cnt  <= !rd_n ? '0 : (rd_hi_cnt == CW'(LIM) ? rd_hi_cnt : rd_hi_cnt + 1'b1);
      wr_lo_cnt  <= wr_n ? '0 : (wr_lo_cnt == CW'(LIM) ? wr_lo_cnt : wr_lo_cnt + 1'b1);
      ale_lo_cnt <= (ale_hi_n && ale_lo_n) ? '0
                  : (ale_lo_cnt == CW'(LIM) ? ale_lo_cnt : ale_lo_cnt + 1'b1);
    end
  end

  p_rd_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi_cnt == CW'(LIM)) |-> !ad_oe);
  p_wr_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_cnt == CW'(LIM)) |-> !ad_oe);
  p_ale_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_lo_cnt == CW'(LIM)) |-> !ad_oe);
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr_q != $past(addr_q)) && !$past(stb[STB_AH].fall) && !$past(stb[STB_AL].fall))
      |-> (addr_q == $past(addr_q) + AW'(2)));
  p_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stb[STB_AH].rise) |-> !armed_q);
  p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stb[STB_AL].fall) |-> armed_q);
endmodule

bind mbt_target mbt_target_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale_hi_n(ale_hi_n), .ale_lo_n(ale_lo_n),
  .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe), .addr_q(addr_q),
  .armed_q(armed_q), .stb(stb)
);

// File: tb/sim_mbt_target.sv
module sim_mbt_target;
  localparam int          MAW    = 8;
  localparam int          DEPTH  = 1 << MAW;
  localparam logic [15:0] REGION = 16'h1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ale_hi_n = 1'b1, ale_lo_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic        h_oe = 1'b0;
  logic [15:0] h_d = '0;
  logic [15:0] ad_i, ad_o;
  logic        ad_oe;

  int unsigned n_chk = 0, n_bad = 0;
  logic [15:0] model [DEPTH];
  logic [31:0] m_addr = '0;
  logic        m_armed = 1'b0;

  always #2 clk = ~clk;
  assign ad_i = h_oe ? h_d : (ad_oe ? ad_o : 16'h0000);

  mbt_target #(.SYNC_STAGES(2), .MEM_AW(MAW), .REGION_HI(REGION)) u0 (
    .clk(clk), .rst_n(rst_n), .ale_hi_n(ale_hi_n), .ale_lo_n(ale_lo_n),
    .rd_n(rd_n), .wr_n(wr_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe)
  );

  function automatic logic hit_of(logic [31:0] a);
    return a[31:16] == REGION;
  endfunction
  function automatic int idx_of(logic [31:0] a);
    return int'(a[MAW:1]);
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_addr(logic [15:0] hi, logic [15:0] lo);
    h_oe = 1'b1; h_d = hi; ale_hi_n = 1'b0; cyc(6);
    check("R7 ale_hi low", {31'd0, ad_oe}, 32'd0);
    ale_hi_n = 1'b1; cyc(6);
    h_d = lo; ale_lo_n = 1'b0; cyc(6);
    check("R7 ale_lo low", {31'd0, ad_oe}, 32'd0);
    ale_lo_n = 1'b1; h_oe = 1'b0; cyc(6);
    m_addr = {hi, lo}; m_armed = 1'b1;
  endtask

  task automatic hi_pulse(logic [15:0] hi);
    h_oe = 1'b1; h_d = hi; ale_hi_n = 1'b0; cyc(6);
    ale_hi_n = 1'b1; h_oe = 1'b0; cyc(6);
    m_addr[31:16] = hi; m_armed = 1'b0;
  endtask

  task automatic do_read(string req);
    logic exp_oe;
    rd_n = 1'b0; cyc(5);
    exp_oe = m_armed && hit_of(m_addr);
    check({req, " oe"}, {31'd0, ad_oe}, {31'd0, exp_oe});
    if (exp_oe) check({req, " data"}, {16'd0, ad_o}, {16'd0, model[idx_of(m_addr)]});
    cyc(1); rd_n = 1'b1; cyc(4);
    check("R8 release", {31'd0, ad_oe}, 32'd0);
    cyc(2);
    if (m_armed) m_addr = m_addr + 32'd2;
  endtask

  task automatic do_write(logic [15:0] d);
    h_oe = 1'b1; h_d = d; wr_n = 1'b0; cyc(3);
    check("R7 wr hiz", {31'd0, ad_oe}, 32'd0);
    cyc(3); wr_n = 1'b1; cyc(6); h_oe = 1'b0;
    if (m_armed && hit_of(m_addr)) model[idx_of(m_addr)] = d;
    if (m_armed) m_addr = m_addr + 32'd2;
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h2468);
    cyc(3);
    check("R1 reset oe", {31'd0, ad_oe}, 32'd0);
    rst_n = 1'b1; cyc(2);
    // R1: disarmed after reset, strobe cycles do not drive
    do_read("R1 disarmed read");

    // R6: fill the array in one burst
    load_addr(REGION, 16'h0000);
    for (int i = 0; i < DEPTH; i++) do_write(16'(i * 37 + 5));
    // R9: burst wrapped, now at index 0 again
    check("R9 wrap addr", {31'd0, (idx_of(m_addr) == 0)}, 32'd1);
    load_addr(REGION, 16'h0000);
    for (int i = 0; i < 8; i++) do_read("R5 R7 seq read");

    // R9: wrap across top entry
    load_addr(REGION, 16'((DEPTH - 1) * 2));
    do_write(16'hCAFE); do_write(16'hBEEF);
    load_addr(REGION, 16'((DEPTH - 1) * 2));
    do_read("R9 top"); do_read("R9 wrap");

    // R2: out of region, no drive and no write
    load_addr(16'h2000, 16'h0010);
    do_read("R2 out-of-region read");
    do_write(16'hDEAD);
    load_addr(REGION, 16'h0010);
    do_read("R2 untouched");

    // R4: disarm via upper strobe, then strobes ignored
    load_addr(REGION, 16'h0040);
    hi_pulse(REGION);
    do_read("R4 disarmed read");
    do_write(16'h5A5A);
    load_addr(REGION, 16'h0040);
    do_read("R4 not written");

    // R3 R5 R6 R7: random bursts
    for (int b = 0; b < 40; b++) begin
      logic [15:0] lo;
      int len;
      lo  = 16'($urandom) & 16'hFFFE;
      len = 1 + int'($urandom % 6);
      load_addr(REGION, lo);
      if ($urandom % 2) begin
        for (int k = 0; k < len; k++) do_write(16'($urandom));
        load_addr(REGION, lo);
      end
      for (int k = 0; k < len; k++) do_read("R3 R5 R6 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule